// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the memory-mapped control front end of a sixteen-channel DMA controller. It decodes single-word register accesses into a channel and a register. For every channel it holds a control/status word, a control-block pointer, a debug word, and read-only copies of the descriptor that the transfer engine is currently running. Two global registers sit beside the channels: a per-channel enable mask and an interrupt summary.

Software starts a channel by setting its run bit. The bank gives the transfer engine a one-cycle start request only on the 0-to-1 edge of that bit. The engine reports back through dedicated inputs: a descriptor load, plus per-channel strobes for completion, interrupt and stop. These inputs win over bus writes in the same cycle. Each channel has one interrupt line, driven from that channel's bit in the summary register.

All sixteen channels share one 4 KiB window. Channel `c` occupies byte offsets `c*0x100` to `c*0x100+0x20`. The two global registers sit at the top of the window.

Top module: `dma_regbank`

## Requirements
- R1: A byte offset selects channel = offset[11:8] and register = offset[7:0], for all channels including channel 15 at 0xF00. The control-block pointer at register 0x04 and the debug word at 0x20 accept full 32-bit writes and read back what was written. Other channels are untouched.
- R2: After reset the enable register (0xFF0) reads 0xFFFF, the interrupt summary (0xFE0) reads 0, and every channel's status word and control-block pointer read 0. All interrupt lines and start requests are low.
- R3: Registers 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C hold, in that order, the descriptor info, source, destination, length, stride and next pointer. They change only through the engine's load port and ignore bus writes.
- R4: A status-word write replaces exactly the bits in mask 0x30FF0001 with the written value and keeps all other bits. Bit 30 (abort) is never stored and has no effect.
- R5: In the status word, bit 1 is done and bit 2 is interrupt. Writing 1 to bit 1 clears done. Writing 1 to either bit never sets it.
- R6: Bit 0 is the run bit. When a write takes the run bit of channel c from 0 to 1, start_o[c] is high for exactly the one cycle after the write. Writing 1 while the bit is already set gives no pulse.
- R7: Writing 1 to bit 31 clears the whole status word and the control-block pointer before the mask update. Bit 31 always reads 0. The channel's summary bit and interrupt line are kept.
- R8: Writing 1 to status bit 2 clears that channel's interrupt flag, its summary bit and its interrupt line.
- R9: Writes to the summary register are ignored. The enable register stores only its low 16 bits and drives enable_o.
- R10: The engine strobes set done, set interrupt (flag, summary bit and line), or clear run and set paused (bit 4). They take priority over a bus write to the same channel in the same cycle. When a stop coincides with a run write, no start pulse is issued.
- R11: Every request is accepted (ready is always high) and answered one cycle later. Unmapped offsets read 0 and ignore writes. A write returns 0 data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_addr_i | input | 10 | Word address (byte offset bits [11:2]) |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_rdata_o | output | 32 | Read data |
| eng_ld_i | input | 1 | Engine loads a descriptor into one channel |
| eng_ld_ch_i | input | 4 | Channel receiving the descriptor |
| eng_info_i | input | 32 | Descriptor info word |
| eng_src_i | input | 32 | Descriptor source address |
| eng_dst_i | input | 32 | Descriptor destination address |
| eng_len_i | input | 32 | Descriptor length |
| eng_stride_i | input | 32 | Descriptor stride |
| eng_next_i | input | 32 | Descriptor next pointer |
| eng_done_i | input | 16 | Per-channel set-done strobe |
| eng_irq_i | input | 16 | Per-channel raise-interrupt strobe |
| eng_stop_i | input | 16 | Per-channel stop strobe (clear run, set paused) |
| start_o | output | 16 | Per-channel one-cycle start request |
| enable_o | output | 16 | Global channel enable mask |
| irq_o | output | 16 | Per-channel interrupt line |

## Verification
The hardest cases to reach are engine strobes that land in the same cycle as a bus write to the same channel. One such case is a raise-interrupt strobe against a write-one-to-clear of the interrupt bit; another is a stop strobe against a run-bit write. The stimulus forks a bus write and an engine pulse so that both hit the same clock edge, then reads back the status word and summary and checks the start line. A second hard case is a channel reset while an interrupt is pending. The bench raises the interrupt through the engine, issues the reset, and confirms that the status word is cleared while the summary bit and the interrupt line stay high.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned ADDR_W = 10;

  // word index inside a channel window
  localparam logic [5:0] W_CS     = 6'd0;
  localparam logic [5:0] W_CBAD   = 6'd1;
  localparam logic [5:0] W_INFO   = 6'd2;
  localparam logic [5:0] W_SRC    = 6'd3;
  localparam logic [5:0] W_DST    = 6'd4;
  localparam logic [5:0] W_LEN    = 6'd5;
  localparam logic [5:0] W_STRIDE = 6'd6;
  localparam logic [5:0] W_NEXT   = 6'd7;
  localparam logic [5:0] W_DBG    = 6'd8;

  localparam logic [ADDR_W-1:0] A_SUMMARY = 10'h3F8;  // byte 0xFE0
  localparam logic [ADDR_W-1:0] A_ENABLE  = 10'h3FC;  // byte 0xFF0

  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_DONE  = 1;
  localparam int unsigned B_IRQ   = 2;
  localparam int unsigned B_PAUSE = 4;
  localparam int unsigned B_CLR   = 31;

  localparam logic [DW-1:0] CS_WMASK = 32'h30FF_0001;

  typedef enum logic [3:0] {
    SEL_CS, SEL_CBAD, SEL_INFO, SEL_SRC, SEL_DST,
    SEL_LEN, SEL_STRIDE, SEL_NEXT, SEL_DBG, SEL_NONE
  } reg_sel_e;

  typedef struct packed {
    logic [DW-1:0] cs;
    logic [DW-1:0] cbad;
    logic [DW-1:0] info;
    logic [DW-1:0] src;
    logic [DW-1:0] dst;
    logic [DW-1:0] len;
    logic [DW-1:0] stride;
    logic [DW-1:0] next;
    logic [DW-1:0] dbg;
  } chan_view_t;
endpackage

// File: rtl/dma_rb_decode.sv
module dma_rb_decode
  import dma_rb_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CH_W   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_ch_o,
  output logic [CH_W-1:0]   ch_o,
  output reg_sel_e          sel_o,
  output logic              hit_sum_o,
  output logic              hit_en_o
);
  reg_sel_e sel_raw;
  logic     ch_ok;

  always_comb begin
    unique case (addr_i[5:0])
      W_CS:     sel_raw = SEL_CS;
      W_CBAD:   sel_raw = SEL_CBAD;
      W_INFO:   sel_raw = SEL_INFO;
      W_SRC:    sel_raw = SEL_SRC;
      W_DST:    sel_raw = SEL_DST;
      W_LEN:    sel_raw = SEL_LEN;
      W_STRIDE: sel_raw = SEL_STRIDE;
      W_NEXT:   sel_raw = SEL_NEXT;
      W_DBG:    sel_raw = SEL_DBG;
      default:  sel_raw = SEL_NONE;
    endcase
  end

  assign ch_ok     = {1'b0, addr_i[9:6]} < 5'(NUM_CH);
  assign hit_sum_o = addr_i == A_SUMMARY;
  assign hit_en_o  = addr_i == A_ENABLE;
  assign hit_ch_o  = ch_ok && (sel_raw != SEL_NONE);
  assign sel_o     = hit_ch_o ? sel_raw : SEL_NONE;
  assign ch_o      = addr_i[6 +: CH_W];
endmodule

// File: rtl/dma_rb_chan.sv
module dma_rb_chan
  import dma_rb_pkg::*;
#(
  parameter int unsigned IDX  = 0,
  parameter int unsigned CH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  reg_sel_e        sel_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            ld_i,
  input  logic [CH_W-1:0] ld_ch_i,
  input  logic [DW-1:0]   info_i,
  input  logic [DW-1:0]   src_i,
  input  logic [DW-1:0]   dst_i,
  input  logic [DW-1:0]   len_i,
  input  logic [DW-1:0]   stride_i,
  input  logic [DW-1:0]   next_i,
  input  logic            done_set_i,
  input  logic            irq_set_i,
  input  logic            stop_i,
  output chan_view_t      view_o,
  output logic            start_o,
  output logic            irq_clr_o
);
  logic [DW-1:0] cs_q, cs_d, cbad_q, dbg_q;
  logic [DW-1:0] info_q, src_q, dst_q, len_q, stride_q, next_q;
  logic          start_q, wr_cs, ld_hit;

  assign wr_cs     = wr_i && (sel_i == SEL_CS);
  assign ld_hit    = ld_i && (ld_ch_i == CH_W'(IDX));
  assign irq_clr_o = wr_cs && wdata_i[B_IRQ];

  always_comb begin
    cs_d = cs_q;
    if (wr_cs) begin
      if (wdata_i[B_CLR])  cs_d = '0;
      if (wdata_i[B_DONE]) cs_d[B_DONE] = 1'b0;
      if (wdata_i[B_IRQ])  cs_d[B_IRQ]  = 1'b0;
      cs_d = (cs_d & ~CS_WMASK) | (wdata_i & CS_WMASK);
    end
    // engine wins over the bus
    if (done_set_i) cs_d[B_DONE] = 1'b1;
    if (irq_set_i)  cs_d[B_IRQ]  = 1'b1;
    if (stop_i) begin
      cs_d[B_RUN]   = 1'b0;
      cs_d[B_PAUSE] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= '0;
      cbad_q  <= '0;
      dbg_q   <= '0;
      start_q <= 1'b0;
    end else begin
      cs_q    <= cs_d;
      start_q <= !cs_q[B_RUN] && cs_d[B_RUN];
      if (wr_cs && wdata_i[B_CLR])       cbad_q <= '0;
      else if (wr_i && sel_i == SEL_CBAD) cbad_q <= wdata_i;
      if (wr_i && sel_i == SEL_DBG)      dbg_q  <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      info_q   <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      len_q    <= '0;
      stride_q <= '0;
      next_q   <= '0;
    end else if (ld_hit) begin
      info_q   <= info_i;
      src_q    <= src_i;
      dst_q    <= dst_i;
      len_q    <= len_i;
      stride_q <= stride_i;
      next_q   <= next_i;
    end
  end

  assign start_o = start_q;
  assign view_o  = '{cs: cs_q, cbad: cbad_q, info: info_q, src: src_q, dst: dst_q,
                     len: len_q, stride: stride_q, next: next_q, dbg: dbg_q};
endmodule

// File: rtl/dma_rb_global.sv
module dma_rb_global #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_wr_i,
  input  logic [NUM_CH-1:0] en_wdata_i,
  input  logic [NUM_CH-1:0] irq_set_i,
  input  logic [NUM_CH-1:0] irq_clr_i,
  output logic [NUM_CH-1:0] enable_o,
  output logic [NUM_CH-1:0] summary_o
);
  logic [NUM_CH-1:0] en_q, sum_q, sum_d;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (irq_set_i[c])      sum_d[c] = 1'b1;
      else if (irq_clr_i[c]) sum_d[c] = 1'b0;
      else                   sum_d[c] = sum_q[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '1;
      sum_q <= '0;
    end else begin
      sum_q <= sum_d;
      if (en_wr_i) en_q <= en_wdata_i;
    end
  end

  assign enable_o  = en_q;
  assign summary_o = sum_q;
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_rb_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_rdata_o,
  input  logic              eng_ld_i,
  input  logic [CH_W-1:0]   eng_ld_ch_i,
  input  logic [DW-1:0]     eng_info_i,
  input  logic [DW-1:0]     eng_src_i,
  input  logic [DW-1:0]     eng_dst_i,
  input  logic [DW-1:0]     eng_len_i,
  input  logic [DW-1:0]     eng_stride_i,
  input  logic [DW-1:0]     eng_next_i,
  input  logic [NUM_CH-1:0] eng_done_i,
  input  logic [NUM_CH-1:0] eng_irq_i,
  input  logic [NUM_CH-1:0] eng_stop_i,
  output logic [NUM_CH-1:0] start_o,
  output logic [NUM_CH-1:0] enable_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic              hit_ch, hit_sum, hit_en, wr_go;
  logic [CH_W-1:0]   ch_idx;
  reg_sel_e          sel;
  chan_view_t        view [NUM_CH];
  logic [NUM_CH-1:0] irq_clr, summary, act_vec, intf_vec;
  logic [DW-1:0]     rd_mux, rdata_q;
  logic              rvalid_q;

  assign req_ready_o = 1'b1;
  assign wr_go       = req_valid_i && req_we_i;

  dma_rb_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
    .addr_i   (req_addr_i),
    .hit_ch_o (hit_ch),
    .ch_o     (ch_idx),
    .sel_o    (sel),
    .hit_sum_o(hit_sum),
    .hit_en_o (hit_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_rb_chan #(.IDX(c), .CH_W(CH_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_go && hit_ch && (ch_idx == CH_W'(c))),
      .sel_i     (sel),
      .wdata_i   (req_wdata_i),
      .ld_i      (eng_ld_i),
      .ld_ch_i   (eng_ld_ch_i),
      .info_i    (eng_info_i),
      .src_i     (eng_src_i),
      .dst_i     (eng_dst_i),
      .len_i     (eng_len_i),
      .stride_i  (eng_stride_i),
      .next_i    (eng_next_i),
      .done_set_i(eng_done_i[c]),
      .irq_set_i (eng_irq_i[c]),
      .stop_i    (eng_stop_i[c]),
      .view_o    (view[c]),
      .start_o   (start_o[c]),
      .irq_clr_o (irq_clr[c])
    );
    assign act_vec[c]  = view[c].cs[B_RUN];
    assign intf_vec[c] = view[c].cs[B_IRQ];
  end

  dma_rb_global #(.NUM_CH(NUM_CH)) u_glb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_wr_i   (wr_go && hit_en),
    .en_wdata_i(req_wdata_i[NUM_CH-1:0]),
    .irq_set_i (eng_irq_i),
    .irq_clr_i (irq_clr),
    .enable_o  (enable_o),
    .summary_o (summary)
  );

  assign irq_o = summary;

  always_comb begin
    rd_mux = '0;
    if (hit_sum)     rd_mux = DW'(summary);
    else if (hit_en) rd_mux = DW'(enable_o);
    else if (hit_ch) begin
      unique case (sel)
        SEL_CS:     rd_mux = view[ch_idx].cs;
        SEL_CBAD:   rd_mux = view[ch_idx].cbad;
        SEL_INFO:   rd_mux = view[ch_idx].info;
        SEL_SRC:    rd_mux = view[ch_idx].src;
        SEL_DST:    rd_mux = view[ch_idx].dst;
        SEL_LEN:    rd_mux = view[ch_idx].len;
        SEL_STRIDE: rd_mux = view[ch_idx].stride;
        SEL_NEXT:   rd_mux = view[ch_idx].next;
        SEL_DBG:    rd_mux = view[ch_idx].dbg;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_valid_i;
      rdata_q  <= (req_valid_i && !req_we_i) ? rd_mux : '0;
    end
  end

  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
  parameter int unsigned NUM_CH = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [NUM_CH-1:0] start_o,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] act_i,
  input logic [NUM_CH-1:0] intf_i
);
  p_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni) req_ready_o);
  p_rsp_after_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_rsp_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_start_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o[c] |-> (act_i[c] && !$past(act_i[c])));
    p_start_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o[c] |=> !start_o[c]);
    p_irq_with_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[c]) |-> intf_i[c]);
  end
endmodule

bind dma_regbank dma_regbank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .start_o    (start_o),
  .irq_o      (irq_o),
  .act_i      (act_vec),
  .intf_i     (intf_vec)
);

// File: tb/tb_dma_regbank.sv
`timescale 1ns/1ps
module tb_dma_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, req_ready;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        eng_ld = 1'b0;
  logic [3:0]  eng_ld_ch = '0;
  logic [31:0] e_info = '0, e_src = '0, e_dst = '0, e_len = '0, e_stride = '0, e_next = '0;
  logic [15:0] eng_done = '0, eng_irq = '0, eng_stop = '0;
  logic [15:0] start, enable, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] exp;
    bit          chk;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  dma_regbank dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .eng_ld_i(eng_ld), .eng_ld_ch_i(eng_ld_ch),
    .eng_info_i(e_info), .eng_src_i(e_src), .eng_dst_i(e_dst),
    .eng_len_i(e_len), .eng_stride_i(e_stride), .eng_next_i(e_next),
    .eng_done_i(eng_done), .eng_irq_i(eng_irq), .eng_stop_i(eng_stop),
    .start_o(start), .enable_o(enable), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !done) begin
      if (sb_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R11 unexpected response act=%h exp=none", rsp_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (it.chk) check(it.tag, rsp_rdata, it.exp);
      end
    end
  end

  task automatic bus(input bit we, input logic [11:0] off, input logic [31:0] wd,
                     input logic [31:0] exp, input bit chk, input string tag);
    item_t it;
    it.exp = exp; it.chk = chk; it.tag = tag;
    @(negedge clk);
    sb_q.push_back(it);
    req_valid = 1'b1; req_we = we; req_addr = off[11:2]; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] wd);
    bus(1'b1, off, wd, 32'h0, 1'b0, "wr");
  endtask

  task automatic rd(input logic [11:0] off, input logic [31:0] exp, input string tag);
    bus(1'b0, off, 32'h0, exp, 1'b1, tag);
  endtask

  task automatic eng_pulse(input logic [15:0] d, input logic [15:0] i, input logic [15:0] s);
    @(negedge clk);
    eng_done = d; eng_irq = i; eng_stop = s;
    @(negedge clk);
    eng_done = '0; eng_irq = '0; eng_stop = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    check("R2 irq after reset", 32'(irq), 32'h0);
    check("R2 start after reset", 32'(start), 32'h0);
    check("R2 enable_o after reset", 32'(enable), 32'hFFFF);
    rd(12'hFF0, 32'h0000_FFFF, "R2 enable reg");
    rd(12'hFE0, 32'h0, "R2 summary reg");
    rd(12'h300, 32'h0, "R2 ch3 status");
    rd(12'h304, 32'h0, "R2 ch3 pointer");

    // R1 decode and writable regs
    wr(12'h004, 32'h1000_0040);
    wr(12'hF04, 32'hABCD_0000);
    wr(12'h720, 32'h0000_55AA);
    rd(12'h004, 32'h1000_0040, "R1 ch0 pointer");
    rd(12'hF04, 32'hABCD_0000, "R1 ch15 pointer");
    rd(12'h720, 32'h0000_55AA, "R1 ch7 debug");
    rd(12'h504, 32'h0, "R1 ch5 untouched");
    rd(12'hF00, 32'h0, "R1 ch15 status");

    // R3 read-only descriptor copies
    wr(12'h108, 32'hFFFF_FFFF);
    rd(12'h108, 32'h0, "R3 info ignores write");
    @(negedge clk);
    eng_ld = 1'b1; eng_ld_ch = 4'd1;
    e_info = 32'h11; e_src = 32'h1000; e_dst = 32'h2000;
    e_len = 32'h40; e_stride = 32'h0004_0008; e_next = 32'h3000;
    @(negedge clk);
    eng_ld = 1'b0;
    wr(12'h10C, 32'h0);
    rd(12'h108, 32'h11, "R3 info");
    rd(12'h10C, 32'h1000, "R3 src after write");
    rd(12'h110, 32'h2000, "R3 dst");
    rd(12'h114, 32'h40, "R3 len");
    rd(12'h118, 32'h0004_0008, "R3 stride");
    rd(12'h11C, 32'h3000, "R3 next");
    rd(12'h208, 32'h0, "R3 ch2 info not loaded");

    // R4 mask, abort bit dropped
    wr(12'h200, 32'h7FFF_FFF8);
    rd(12'h200, 32'h30FF_0000, "R4 masked status");

    // R6 start edge
    wr(12'h200, 32'h0000_0001);
    check("R6 start pulse", 32'(start), 32'h0004);
    @(negedge clk);
    check("R6 start one cycle", 32'(start), 32'h0);
    wr(12'h200, 32'h0000_0001);
    check("R6 no start when running", 32'(start), 32'h0);
    rd(12'h200, 32'h1, "R6 status running");

    // R10 engine completion
    eng_pulse(16'h0004, 16'h0004, 16'h0004);
    check("R10 irq line", 32'(irq), 32'h0004);
    rd(12'h200, 32'h16, "R10 done irq paused");
    rd(12'hFE0, 32'h4, "R10 summary");

    // R4 keep non-masked bits
    wr(12'h200, 32'h0001_0000);
    rd(12'h200, 32'h0001_0016, "R4 keep flags");
    // R5 done clear
    wr(12'h200, 32'h0000_0002);
    rd(12'h200, 32'h14, "R5 done cleared");
    check("R5 irq kept on done clear", 32'(irq), 32'h0004);
    // R8 irq clear
    wr(12'h200, 32'h0000_0004);
    rd(12'h200, 32'h10, "R8 flag cleared");
    check("R8 irq line dropped", 32'(irq), 32'h0);
    rd(12'hFE0, 32'h0, "R8 summary cleared");

    // R10 engine set wins over clear
    fork
      wr(12'h200, 32'h0000_0004);
      eng_pulse(16'h0, 16'h0004, 16'h0);
    join
    rd(12'h200, 32'h14, "R10 set beats clear");
    rd(12'hFE0, 32'h4, "R10 summary set wins");
    // R10 stop beats run write
    fork
      wr(12'h200, 32'h0000_0001);
      eng_pulse(16'h0, 16'h0, 16'h0004);
    join
    check("R10 no start under stop", 32'(start), 32'h0);
    rd(12'h200, 32'h14, "R10 stop beats run");

    // R9 summary ignores writes
    wr(12'hFE0, 32'h0);
    rd(12'hFE0, 32'h4, "R9 summary write ignored");

    // R7 channel reset keeps summary
    wr(12'h204, 32'h0000_0200);
    rd(12'h204, 32'h200, "R1 ch2 pointer");
    wr(12'h200, 32'h8000_0000);
    rd(12'h200, 32'h0, "R7 status cleared");
    rd(12'h204, 32'h0, "R7 pointer cleared");
    rd(12'hFE0, 32'h4, "R7 summary kept");
    check("R7 irq kept", 32'(irq), 32'h0004);
    wr(12'h200, 32'h0000_0004);
    check("R8 irq after reset clear", 32'(irq), 32'h0);

    // R9 enable
    wr(12'hFF0, 32'hFFFF_0F0F);
    rd(12'hFF0, 32'h0000_0F0F, "R9 enable low half");
    check("R9 enable_o", 32'(enable), 32'h0F0F);

    // R11 unmapped
    rd(12'h024, 32'h0, "R11 past debug");
    wr(12'h030, 32'hFFFF_FFFF);
    rd(12'h030, 32'h0, "R11 unmapped write");
    rd(12'hFE4, 32'h0, "R11 gap global");
    rd(12'hF24, 32'h0, "R11 ch15 gap");
    check("R11 ready", 32'(req_ready), 32'h1);

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL R11 missing responses act=%0d exp=0", sb_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule